// File: doc/BRIEF.md
# ADC Conversion Clock and Paired-Sample Readout Sequencer

This block runs an external ADC with a parallel output from a single system clock. It divides the system clock into a square conversion clock for the converter. After each falling edge of that clock, it waits a fixed number of system clocks. It then pulls an active-low read strobe for three system-clock periods and latches the ADC data bus at the end of the middle period.

Latched samples are grouped two at a time. Each pair is emitted as one double-width word, with the earlier sample in the upper half, together with a one-cycle valid pulse. The output rate is therefore half the sample rate.

With the default divide ratio of 100 and a 49.152 MHz system clock, the conversion clock runs at 491.52 kHz. An active-low asynchronous reset returns the divider, the strobe and the pairing logic to their idle state.

Top module: `adc_rd_sequencer`

## Requirements
- R1: While reset is held and on the first cycle after its release, `cnv_clk` is 0, `ren_n` is 1, `out_valid` is 0 and `out_word` is 0.
- R2: Counting rising system-clock edges from reset release as n = 1, 2, ..., `cnv_clk` is 1 exactly when (n mod DIV) is at least DIV/2. It is therefore low for DIV/2 clocks, then high for DIV/2 clocks, repeating.
- R3: `ren_n` goes low RD_DELAY system clocks after each falling edge of `cnv_clk` and stays low for exactly three system-clock periods. With defaults this covers the cycles following edges n with n mod 100 in {4, 5, 6}, for n of at least 100.
- R4: The sample taken for a read is the value on `adc_data` during the second of the three low periods of `ren_n`, latched at the edge that ends that period.
- R5: `out_word` holds the two samples of a pair with the first captured in bits [2*SAMPLE_W-1:SAMPLE_W] and the second in bits [SAMPLE_W-1:0].
- R6: `out_valid` is a one-cycle pulse that is high in the cycle right after the second sample of a pair is latched. There is exactly one pulse per two samples, and no pulse after the first sample of a pair.
- R7: Reset empties the pairing register, so the first capture after reset starts a new pair even if a half-filled pair existed before.
- R8: Outside its three-cycle read window, `ren_n` stays high, and only one read window occurs in each conversion period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnv_clk | output | 1 | Conversion clock to the ADC, system clock / DIV |
| ren_n | output | 1 | Read strobe to the ADC, active low |
| adc_data | input | SAMPLE_W | ADC parallel data bus |
| out_word | output | 2*SAMPLE_W | Paired sample word, first sample in the upper half |
| out_valid | output | 1 | One-cycle strobe marking a new `out_word` |

## Verification
The assertions assume the parameters keep the read window inside the low half of the conversion clock, that is, RD_DELAY plus three is below DIV/2. They also assume reset is the only input that can disturb the timing, since the divider and strobe depend on nothing else. The ADC bus is taken as free-running data whose value in the middle read cycle is what gets latched.

The bench drives a new, distinct value onto the bus every cycle as a function of the cycle number. This lets a capture one cycle early or late be seen in the packed word. The bench applies reset only between clock edges, once at the start and once with a pair left half full.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_WAIT = 2'd1,
    RS_READ = 2'd2
  } rd_state_t;

  localparam int unsigned RD_LEN = 3;
  localparam int unsigned RD_MID = 1;
endpackage

// File: rtl/adc_cnv_div.sv
module adc_cnv_div #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic cnv_clk,
  output logic fall_now
);
  localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned HALF = DIV / 2;

  logic [CW-1:0] cnt_q;
  logic          cnv_q;

  // the edge at which cnv_q drops back to 0
  assign fall_now = (cnt_q == CW'(DIV - 1));
  assign cnv_clk  = cnv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cnv_q <= 1'b0;
    end else begin
      if (fall_now) begin
        cnt_q <= '0;
        cnv_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(HALF - 1)) cnv_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
  import adc_rd_pkg::*;
#(
  parameter int unsigned RD_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_now,
  output logic ren_n,
  output logic cap_en
);
  localparam int unsigned WW = $clog2(RD_DELAY + 1);
  localparam int unsigned PW = $clog2(RD_LEN);

  rd_state_t     st_q;
  logic [WW-1:0] wait_q;
  logic [PW-1:0] ph_q;
  logic          ren_q;

  assign ren_n  = ren_q;
  assign cap_en = (st_q == RS_READ) && (ph_q == PW'(RD_MID));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      wait_q <= '0;
      ph_q   <= '0;
      ren_q  <= 1'b1;
    end else begin
      case (st_q)
        RS_IDLE: begin
          if (fall_now) begin
            wait_q <= WW'(RD_DELAY - 1);
            st_q   <= RS_WAIT;
          end
        end
        RS_WAIT: begin
          if (wait_q == '0) begin
            st_q  <= RS_READ;
            ph_q  <= '0;
            ren_q <= 1'b0;
          end else begin
            wait_q <= wait_q - 1'b1;
          end
        end
        RS_READ: begin
          if (ph_q == PW'(RD_LEN - 1)) begin
            ren_q <= 1'b1;
            st_q  <= RS_IDLE;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: begin
          st_q  <= RS_IDLE;
          ren_q <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_pair_pack.sv
module adc_pair_pack #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_en,
  input  logic [SAMPLE_W-1:0]   din,
  output logic [2*SAMPLE_W-1:0] word,
  output logic                  valid
);
  logic                  have_first_q;
  logic [SAMPLE_W-1:0]   first_q;
  logic [2*SAMPLE_W-1:0] word_q;
  logic                  valid_q;

  assign word  = word_q;
  assign valid = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_first_q <= 1'b0;
      first_q      <= '0;
      word_q       <= '0;
      valid_q      <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (cap_en) begin
        if (!have_first_q) begin
          first_q      <= din;
          have_first_q <= 1'b1;
        end else begin
          word_q       <= {first_q, din};
          valid_q      <= 1'b1;
          have_first_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/adc_rd_sequencer.sv
module adc_rd_sequencer #(
  parameter int unsigned DIV      = 100,
  parameter int unsigned RD_DELAY = 4,
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic                  cnv_clk,
  output logic                  ren_n,
  input  logic [SAMPLE_W-1:0]   adc_data,
  output logic [2*SAMPLE_W-1:0] out_word,
  output logic                  out_valid
);
  logic fall_now;
  logic cap_en;

  adc_cnv_div #(.DIV(DIV)) div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnv_clk  (cnv_clk),
    .fall_now (fall_now)
  );

  adc_read_seq #(.RD_DELAY(RD_DELAY)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_now (fall_now),
    .ren_n    (ren_n),
    .cap_en   (cap_en)
  );

  adc_pair_pack #(.SAMPLE_W(SAMPLE_W)) pack_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .din    (adc_data),
    .word   (out_word),
    .valid  (out_valid)
  );
endmodule

// File: rtl/adc_rd_sequencer_chk.sv
module adc_rd_sequencer_chk #(
  parameter int unsigned DIV = 100
) (
  input logic clk,
  input logic rst_n,
  input logic cnv_clk,
  input logic ren_n,
  input logic out_valid
);
  localparam int unsigned HALF = DIV / 2;

  logic        cnv_d;
  int unsigned run_cnt;
  int unsigned low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_d   <= 1'b0;
      run_cnt <= 0;
      low_cnt <= 0;
    end else begin
      cnv_d   <= cnv_clk;
      run_cnt <= (cnv_clk != cnv_d) ? 1 : run_cnt + 1;
      low_cnt <= ren_n ? 0 : low_cnt + 1;
    end
  end

  // R2
  cnv_half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_clk != cnv_d) |-> (run_cnt == HALF));

  // R3
  ren_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ren_n) |-> (low_cnt == 3));

  // R8
  ren_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= 3);

  // R3
  ren_in_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ren_n |-> !cnv_clk);

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6
  valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!ren_n && !$past(ren_n)));
endmodule

bind adc_rd_sequencer adc_rd_sequencer_chk #(.DIV(DIV)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnv_clk   (cnv_clk),
  .ren_n     (ren_n),
  .out_valid (out_valid)
);

// File: tb/adc_rd_sequencer_tb_top.sv
module adc_rd_sequencer_tb_top;
  localparam int unsigned CLK_PERIOD = 20;
  localparam int unsigned SW = 16;
  localparam int unsigned NTAB = 12;
  localparam int unsigned TAB_CYC [NTAB] = '{1, 49, 50, 99, 100, 103, 104, 106, 107, 150, 204, 207};
  localparam bit          TAB_CNV [NTAB] = '{0, 0, 1, 1, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam bit          TAB_REN [NTAB] = '{1, 1, 1, 1, 1, 1, 0, 0, 1, 1, 0, 1};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cnv_clk, ren_n, out_valid;
  logic [SW-1:0] adc_data;
  logic [2*SW-1:0] out_word;

  int errors = 0;
  int checks = 0;
  int n = 0;
  int n_valid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_rd_sequencer #(.DIV(100), .RD_DELAY(4), .SAMPLE_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnv_clk(cnv_clk), .ren_n(ren_n),
    .adc_data(adc_data), .out_word(out_word), .out_valid(out_valid)
  );

  function automatic logic [SW-1:0] dval(int m);
    return SW'((m * 37 + 11) ^ (m << 5));
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at n=%0d: actual=%0h expected=%0h", req, n, act, exp);
    end
  endtask

  // one rising edge, then check and drive at the falling edge
  task automatic step_model(bit full);
    bit ev;
    @(posedge clk);
    n++;
    @(negedge clk);
    ev = (n >= 206) && (n % 200 == 6);
    if (full) begin
      chk("R2 cnv_clk", 64'(cnv_clk), 64'((n % 100) >= 50));
      chk("R3/R8 ren_n", 64'(ren_n),
          64'(!((n >= 100) && ((n % 100) >= 4) && ((n % 100) <= 6))));
    end
    chk("R6 out_valid", 64'(out_valid), 64'(ev));
    if (ev) begin
      n_valid++;
      chk("R4/R5 out_word", 64'(out_word), 64'({dval(n - 101), dval(n - 1)}));
    end
    adc_data = dval(n);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired at n=%0d: actual=running expected=done", n);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ti;
    rst_n = 1'b0;
    adc_data = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 cnv_clk reset", 64'(cnv_clk), 64'd0);
    chk("R1 ren_n reset", 64'(ren_n), 64'd1);
    chk("R1 out_valid reset", 64'(out_valid), 64'd0);
    chk("R1 out_word reset", 64'(out_word), 64'd0);
    rst_n = 1'b1;
    n = 0;
    adc_data = dval(0);

    // main walk with table spot checks
    ti = 0;
    for (int c = 0; c < 820; c++) begin
      step_model(1'b1);
      if (ti < NTAB && n == TAB_CYC[ti]) begin
        chk("R2 table cnv_clk", 64'(cnv_clk), 64'(TAB_CNV[ti]));
        chk("R3 table ren_n", 64'(ren_n), 64'(TAB_REN[ti]));
        if (n == 1) chk("R1 out_word after release", 64'(out_word), 64'd0);
        ti++;
      end
    end
    // four pairs expected: n = 206, 406, 606, 806
    chk("R6 pair count", 64'(n_valid), 64'd4);

    // R7: reset with half a pair latched (after capture at n=106 of the new run)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 ren_n mid reset", 64'(ren_n), 64'd1);
    chk("R1 cnv_clk mid reset", 64'(cnv_clk), 64'd0);
    rst_n = 1'b1;
    n = 0;
    adc_data = dval(0);
    for (int c = 0; c < 150; c++) step_model(1'b1);
    // now one sample (n=106) is held; reset again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    n_valid = 0;
    adc_data = dval(0);
    // R7: the pair must restart, so no pulse at n=106 and one at n=206
    for (int c = 0; c < 230; c++) step_model(1'b1);
    chk("R7 pair count after reset", 64'(n_valid), 64'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule